// File: doc/BRIEF.md
# Radix-2 Butterfly with Three-Multiplier Twiddle Product

This block is one radix-2 decimation-in-time FFT butterfly. In each transfer it takes two complex samples A and B and a twiddle index k. It first rotates B by the twiddle factor W_k = exp(-j2πk/N). It then returns the sum A + W·B and the difference A − W·B.

The rotation needs only three real multipliers. A small table, computed when the design is built, holds three numbers for each index: the cosine term, the cosine plus the sine, and the sine minus the cosine. No twiddle parts are added while the block runs. Each output adds its operands in carry-save form, through 3:2 or 4:2 compressor rows. One carry-propagate adder per output then gives the final value, which is scaled back by the twiddle fraction width.

An optional register sits after the multipliers. A qualifying valid signal travels with the data through that register. A surrounding FFT engine sends one butterfly per valid cycle and takes the results when valid_o is high.

Top module: `fft_bfly3m`

## Requirements
- R1: For each index k the table value is c = round(2^14·cos(2πk/N)) and s = round(−2^14·sin(2πk/N)), where round means floor(x + 0.5) and W = c + j·s. Every valid output uses these values.
- R2: y0_re_o = floor((a_re·2^14 + c·b_re − s·b_im) / 2^14) and y0_im_o = floor((a_im·2^14 + c·b_im + s·b_re) / 2^14).
- R3: y1_re_o = floor((a_re·2^14 − (c·b_re − s·b_im)) / 2^14) and y1_im_o = floor((a_im·2^14 − (c·b_im + s·b_re)) / 2^14).
- R4: With tw_idx_i = 0, the outputs are exactly A + B and A − B, with no rounding error.
- R5: With PIPE = 1, valid_o is valid_i delayed by one clock. The results for a sample appear in the cycle in which its valid_o is high.
- R6: A cycle with valid_i low leaves all four outputs unchanged, whatever the data and index inputs do.
- R7: While rst_ni is low, and after it rises until the first valid sample arrives, valid_o is 0 and all four outputs are 0.
- R8: Inputs at the most negative value (−32768) and at the largest positive value give results that do not wrap. The outputs are DW+2 = 18 bits wide.
- R9: For every valid result, (y0 + y1) − 2·a is 0 or −1, in both the real and the imaginary part.
- R10: With B = 0, both outputs equal A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input sample qualifier |
| a_re_i | input | DW | Real part of A, two's complement |
| a_im_i | input | DW | Imaginary part of A |
| b_re_i | input | DW | Real part of B |
| b_im_i | input | DW | Imaginary part of B |
| tw_idx_i | input | log2(N/2) | Twiddle index k |
| valid_o | output | 1 | Output qualifier |
| y0_re_o | output | DW+2 | Real part of A + W·B |
| y0_im_o | output | DW+2 | Imaginary part of A + W·B |
| y1_re_o | output | DW+2 | Real part of A − W·B |
| y1_im_o | output | DW+2 | Imaginary part of A − W·B |

## Verification
The bench computes W·B with the usual four products and compares all four outputs on every clock, for every twiddle index. A design that swapped the c+s and s−c terms, or that lost a +1 inversion constant in a subtraction lane, would be off in one lane by a full product or by one LSB. Corner inputs where every part is −32768 or +32767 would expose an operand that was too narrow or sign-extended wrongly, which shows up as a wrapped output. Index 0 and B = 0 pin down exact sums. Idle cycles with moving data check that a design capturing without valid changes its outputs when it should not.

// File: rtl/fft_bfly_pkg.sv
package fft_bfly_pkg;

  localparam real TWO_PI = 6.283185307179586;

  // round(2^frac * cos(2*pi*k/n)) with round = floor(x+0.5)
  function automatic int tw_cos_q(int k, int n, int frac);
    real x;
    x = $cos(TWO_PI * real'(k) / real'(n)) * real'(1 << frac);
    return $rtoi($floor(x + 0.5));
  endfunction

  // round(-2^frac * sin(2*pi*k/n))
  function automatic int tw_sin_q(int k, int n, int frac);
    real x;
    x = -$sin(TWO_PI * real'(k) / real'(n)) * real'(1 << frac);
    return $rtoi($floor(x + 0.5));
  endfunction

endpackage

// File: rtl/bfly_tw_rom.sv
module bfly_tw_rom #(
  parameter int TW   = 16,
  parameter int FRAC = 14,
  parameter int NPT  = 16,
  localparam int NH  = NPT / 2,
  localparam int IW  = $clog2(NH)
) (
  input  logic        [IW-1:0] idx_i,
  output logic signed [TW-1:0] c_o,
  output logic signed [TW-1:0] cps_o,
  output logic signed [TW-1:0] smc_o
);
  logic signed [TW-1:0] tab_c   [NH];
  logic signed [TW-1:0] tab_cps [NH];
  logic signed [TW-1:0] tab_smc [NH];

  for (genvar k = 0; k < NH; k++) begin : g_ent
    localparam int CV = fft_bfly_pkg::tw_cos_q(k, NPT, FRAC);
    localparam int SV = fft_bfly_pkg::tw_sin_q(k, NPT, FRAC);
    assign tab_c[k]   = TW'(CV);
    assign tab_cps[k] = TW'(CV + SV);
    assign tab_smc[k] = TW'(SV - CV);
  end

  assign c_o   = tab_c[idx_i];
  assign cps_o = tab_cps[idx_i];
  assign smc_o = tab_smc[idx_i];
endmodule

// File: rtl/bfly_amul.sv
// Signed array multiplier: one partial-product row per bit of b, MSB row negative.
module bfly_amul #(
  parameter int AW  = 16,
  parameter int BW  = 16,
  localparam int PW = AW + BW
) (
  input  logic signed [AW-1:0] a_i,
  input  logic signed [BW-1:0] b_i,
  output logic signed [PW-1:0] p_o
);
  logic signed [PW-1:0] a_x;
  assign a_x = PW'(a_i);

  always_comb begin
    p_o = '0;
    for (int i = 0; i < BW; i++) begin
      if (b_i[i]) begin
        if (i == BW - 1) p_o = p_o - (a_x <<< i);
        else             p_o = p_o + (a_x <<< i);
      end
    end
  end
endmodule

// File: rtl/bfly_csa32.sv
module bfly_csa32 #(
  parameter int W = 32
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic [W-1:0] z_i,
  output logic [W-1:0] s_o,
  output logic [W-1:0] c_o
);
  logic [W-2:0] maj;
  assign s_o = x_i ^ y_i ^ z_i;
  assign maj = (x_i[W-2:0] & y_i[W-2:0]) | (x_i[W-2:0] & z_i[W-2:0]) |
               (y_i[W-2:0] & z_i[W-2:0]);
  assign c_o = {maj, 1'b0};
endmodule

// File: rtl/bfly_csa42.sv
// 4:2 reduction as two stacked full-adder rows; depth is two cells, no carry ripple.
module bfly_csa42 #(
  parameter int W = 32
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic [W-1:0] z_i,
  input  logic [W-1:0] w_i,
  output logic [W-1:0] s_o,
  output logic [W-1:0] c_o
);
  logic [W-1:0] s1, c1;
  bfly_csa32 #(.W(W)) u_row0 (.x_i(x_i), .y_i(y_i), .z_i(z_i), .s_o(s1), .c_o(c1));
  bfly_csa32 #(.W(W)) u_row1 (.x_i(s1), .y_i(c1), .z_i(w_i), .s_o(s_o), .c_o(c_o));
endmodule

// File: rtl/fft_bfly3m.sv
module fft_bfly3m #(
  parameter int DW   = 16,
  parameter int TW   = 16,
  parameter int FRAC = 14,
  parameter int NPT  = 16,
  parameter bit PIPE = 1'b1,
  localparam int NH  = NPT / 2,
  localparam int IW  = $clog2(NH),
  localparam int OW  = DW + 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic signed [DW-1:0] a_re_i,
  input  logic signed [DW-1:0] a_im_i,
  input  logic signed [DW-1:0] b_re_i,
  input  logic signed [DW-1:0] b_im_i,
  input  logic        [IW-1:0] tw_idx_i,
  output logic                 valid_o,
  output logic signed [OW-1:0] y0_re_o,
  output logic signed [OW-1:0] y0_im_o,
  output logic signed [OW-1:0] y1_re_o,
  output logic signed [OW-1:0] y1_im_o
);
  localparam int PW1 = TW + DW + 1;
  localparam int PW2 = TW + DW;
  localparam int SW  = TW + DW + 3;

  logic signed [TW-1:0] tw_c, tw_cps, tw_smc;
  bfly_tw_rom #(.TW(TW), .FRAC(FRAC), .NPT(NPT)) u_rom (
    .idx_i(tw_idx_i), .c_o(tw_c), .cps_o(tw_cps), .smc_o(tw_smc)
  );

  logic signed [DW:0] b_sum;
  assign b_sum = (DW+1)'(b_re_i) + (DW+1)'(b_im_i);

  logic signed [PW1-1:0] p1;
  logic signed [PW2-1:0] p2, p3;
  bfly_amul #(.AW(TW), .BW(DW+1)) u_m1 (.a_i(tw_c),   .b_i(b_sum),  .p_o(p1));
  bfly_amul #(.AW(TW), .BW(DW))   u_m2 (.a_i(tw_smc), .b_i(b_re_i), .p_o(p2));
  bfly_amul #(.AW(TW), .BW(DW))   u_m3 (.a_i(tw_cps), .b_i(b_im_i), .p_o(p3));

  logic [SW-1:0] k1_d, k2_d, k3_d, ar_d, ai_d;
  assign k1_d = {{(SW-PW1){p1[PW1-1]}}, p1};
  assign k2_d = {{(SW-PW2){p2[PW2-1]}}, p2};
  assign k3_d = {{(SW-PW2){p3[PW2-1]}}, p3};
  assign ar_d = {{(SW-DW-FRAC){a_re_i[DW-1]}}, a_re_i, {FRAC{1'b0}}};
  assign ai_d = {{(SW-DW-FRAC){a_im_i[DW-1]}}, a_im_i, {FRAC{1'b0}}};

  logic [SW-1:0] k1, k2, k3, ar, ai;
  logic          vld;

  if (PIPE) begin : g_pipe
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld <= 1'b0;
        k1 <= '0; k2 <= '0; k3 <= '0; ar <= '0; ai <= '0;
      end else begin
        vld <= valid_i;
        if (valid_i) begin
          k1 <= k1_d; k2 <= k2_d; k3 <= k3_d; ar <= ar_d; ai <= ai_d;
        end
      end
    end
  end else begin : g_comb
    assign vld = valid_i;
    assign k1 = k1_d; assign k2 = k2_d; assign k3 = k3_d;
    assign ar = ar_d; assign ai = ai_d;
  end

  // Lanes: 0 y0_re, 1 y1_re, 2 y0_im, 3 y1_im. Negation = invert + constant.
  logic [SW-1:0] op   [4][4];
  logic [SW-1:0] cs_s [4];
  logic [SW-1:0] cs_c [4];
  logic [OW-1:0] y_l  [4];

  assign op[0] = '{ar, k1,  ~k3, SW'(1)};
  assign op[1] = '{ar, ~k1, k3,  SW'(1)};
  assign op[2] = '{ai, k1,  k2,  '0};
  assign op[3] = '{ai, ~k1, ~k2, SW'(2)};

  for (genvar g = 0; g < 4; g++) begin : g_lane
    logic [SW-1:0] sum;
    if (g == 2) begin : g_c32
      logic unused_op3;
      assign unused_op3 = ^op[g][3];
      bfly_csa32 #(.W(SW)) u_csa (
        .x_i(op[g][0]), .y_i(op[g][1]), .z_i(op[g][2]),
        .s_o(cs_s[g]), .c_o(cs_c[g])
      );
    end else begin : g_c42
      bfly_csa42 #(.W(SW)) u_csa (
        .x_i(op[g][0]), .y_i(op[g][1]), .z_i(op[g][2]), .w_i(op[g][3]),
        .s_o(cs_s[g]), .c_o(cs_c[g])
      );
    end
    assign sum    = cs_s[g] + cs_c[g];
    assign y_l[g] = sum[FRAC +: OW];
    logic unused_bits;
    assign unused_bits = ^{sum[FRAC-1:0], sum[SW-1:FRAC+OW]};
  end

  assign valid_o = vld;
  assign y0_re_o = y_l[0];
  assign y1_re_o = y_l[1];
  assign y0_im_o = y_l[2];
  assign y1_im_o = y_l[3];
endmodule

// File: rtl/fft_bfly3m_chk.sv
module fft_bfly3m_chk #(
  parameter int DW   = 16,
  parameter int TW   = 16,
  parameter int FRAC = 14,
  parameter int NPT  = 16,
  parameter bit PIPE = 1'b1,
  localparam int NH  = NPT / 2,
  localparam int IW  = $clog2(NH),
  localparam int OW  = DW + 2
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 valid_i,
  input logic signed [DW-1:0] a_re_i,
  input logic signed [DW-1:0] a_im_i,
  input logic signed [DW-1:0] b_re_i,
  input logic signed [DW-1:0] b_im_i,
  input logic        [IW-1:0] tw_idx_i,
  input logic                 valid_o,
  input logic signed [OW-1:0] y0_re_o,
  input logic signed [OW-1:0] y0_im_o,
  input logic signed [OW-1:0] y1_re_o,
  input logic signed [OW-1:0] y1_im_o
);
  logic                 live_q, v_q;
  logic signed [DW-1:0] ar_q, ai_q, br_q, bi_q;
  logic        [IW-1:0] k_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_q <= 1'b0; v_q <= 1'b0;
      ar_q <= '0; ai_q <= '0; br_q <= '0; bi_q <= '0; k_q <= '0;
    end else begin
      live_q <= 1'b1; v_q <= valid_i;
      ar_q <= a_re_i; ai_q <= a_im_i; br_q <= b_re_i; bi_q <= b_im_i; k_q <= tw_idx_i;
    end
  end

  logic signed [OW+1:0] d_re, d_im;

  // R7
  rst_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !live_q |-> (!valid_o && y0_re_o == '0 && y0_im_o == '0 &&
                 y1_re_o == '0 && y1_im_o == '0));

  if (PIPE) begin : g_seq
    assign d_re = (OW+2)'(y0_re_o) + (OW+2)'(y1_re_o) - ((OW+2)'(ar_q) <<< 1);
    assign d_im = (OW+2)'(y0_im_o) + (OW+2)'(y1_im_o) - ((OW+2)'(ai_q) <<< 1);

    // R5
    vld_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      live_q |-> (valid_o == v_q));

    // R6
    idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (live_q && !v_q) |-> ($stable(y0_re_o) && $stable(y0_im_o) &&
                            $stable(y1_re_o) && $stable(y1_im_o)));

    // R9
    pair_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (live_q && valid_o) |-> ((d_re == 0 || d_re == -1) && (d_im == 0 || d_im == -1)));

    // R4
    idx0_exact_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (live_q && valid_o && k_q == '0) |->
        (y0_re_o == OW'(ar_q) + OW'(br_q) && y1_re_o == OW'(ar_q) - OW'(br_q) &&
         y0_im_o == OW'(ai_q) + OW'(bi_q) && y1_im_o == OW'(ai_q) - OW'(bi_q)));

    // R10
    b_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (live_q && valid_o && br_q == '0 && bi_q == '0) |->
        (y0_re_o == OW'(ar_q) && y1_re_o == OW'(ar_q) &&
         y0_im_o == OW'(ai_q) && y1_im_o == OW'(ai_q)));
  end else begin : g_cmb
    assign d_re = (OW+2)'(y0_re_o) + (OW+2)'(y1_re_o) - ((OW+2)'(a_re_i) <<< 1);
    assign d_im = (OW+2)'(y0_im_o) + (OW+2)'(y1_im_o) - ((OW+2)'(a_im_i) <<< 1);
    always_comb begin
      if (rst_ni && valid_i) begin
        // R9
        pair_sum_cmb_chk: assert ((d_re == 0 || d_re == -1) && (d_im == 0 || d_im == -1));
        // R10
        if (b_re_i == '0 && b_im_i == '0)
          b_zero_cmb_chk: assert (y0_re_o == OW'(a_re_i) && y1_im_o == OW'(a_im_i));
      end
    end
  end
endmodule

bind fft_bfly3m fft_bfly3m_chk #(
  .DW(DW), .TW(TW), .FRAC(FRAC), .NPT(NPT), .PIPE(PIPE)
) i_chk (.*);

// File: tb/test_fft_bfly3m.sv
module test_fft_bfly3m;
  localparam int CLK_NS = 10;
  localparam int DW = 16, OW = 18, NPT = 16, NH = 8, IW = 3, FRAC = 14;
  localparam real PI2 = 6.283185307179586;

  logic                 clk = 1'b0, rst_ni = 1'b1, valid_i = 1'b0;
  logic signed [DW-1:0] a_re_i = '0, a_im_i = '0, b_re_i = '0, b_im_i = '0;
  logic        [IW-1:0] tw_idx_i = '0;
  logic                 valid_o;
  logic signed [OW-1:0] y0_re_o, y0_im_o, y1_re_o, y1_im_o;

  fft_bfly3m i_fft_bfly3m (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i),
    .a_re_i(a_re_i), .a_im_i(a_im_i), .b_re_i(b_re_i), .b_im_i(b_im_i),
    .tw_idx_i(tw_idx_i), .valid_o(valid_o),
    .y0_re_o(y0_re_o), .y0_im_o(y0_im_o), .y1_re_o(y1_re_o), .y1_im_o(y1_im_o)
  );

  always #(CLK_NS/2) clk = ~clk;

  int     n_chk = 0, n_fail = 0;
  bit     m_v = 1'b0;
  longint m_y [4] = '{0, 0, 0, 0};
  string  m_tag = "R7";

  function automatic longint rnd_q(real x);
    return longint'($floor(x + 0.5));
  endfunction

  // R1: twiddle values; R2/R3: four-multiplier reference
  task automatic model(int ar, int ai, int br, int bi, int k);
    longint c, s, wr, wi;
    c  = rnd_q(16384.0 * $cos(PI2 * real'(k) / real'(NPT)));
    s  = rnd_q(-16384.0 * $sin(PI2 * real'(k) / real'(NPT)));
    wr = c * br - s * bi;
    wi = c * bi + s * br;
    m_y[0] = ((longint'(ar) <<< FRAC) + wr) >>> FRAC;
    m_y[1] = ((longint'(ar) <<< FRAC) - wr) >>> FRAC;
    m_y[2] = ((longint'(ai) <<< FRAC) + wi) >>> FRAC;
    m_y[3] = ((longint'(ai) <<< FRAC) - wi) >>> FRAC;
  endtask

  task automatic check();
    longint act [4];
    act = '{longint'(y0_re_o), longint'(y1_re_o), longint'(y0_im_o), longint'(y1_im_o)};
    n_chk++;
    if (valid_o !== m_v) begin
      n_fail++;
      $display("FAIL %s valid_o act=%0b exp=%0b", m_tag, valid_o, m_v);
    end
    for (int i = 0; i < 4; i++) begin
      if (act[i] != m_y[i]) begin
        n_fail++;
        $display("FAIL %s lane%0d act=%0d exp=%0d", m_tag, i, act[i], m_y[i]);
      end
    end
  endtask

  // Compare the result of the previous step, then drive the next sample.
  task automatic step(bit v, int ar, int ai, int br, int bi, int k, string tag);
    @(negedge clk);
    check();
    valid_i = v;
    a_re_i = DW'(ar); a_im_i = DW'(ai); b_re_i = DW'(br); b_im_i = DW'(bi);
    tw_idx_i = IW'(k);
    m_v = v;
    m_tag = tag;
    if (v) model(ar, ai, br, bi, k);
  endtask

  function automatic int r16();
    return int'($signed(16'($urandom)));
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1 rst_ni = 1'b0;
    valid_i = 1'b1; a_re_i = 16'sd1234; b_re_i = 16'sd77;
    repeat (3) begin @(negedge clk); check(); end  // R7 during reset
    rst_ni = 1'b1;
    valid_i = 1'b0;
    repeat (2) step(1'b0, r16(), r16(), r16(), r16(), 1, "R7");

    for (int i = 0; i < 8; i++) step(1'b1, r16(), r16(), r16(), r16(), 0, "R4");
    for (int k = 0; k < NH; k++)
      for (int j = 0; j < 6; j++) step(1'b1, r16(), r16(), r16(), r16(), k, "R1 R2 R3");
    for (int k = 0; k < NH; k++) begin
      step(1'b1, -32768, -32768, -32768, -32768, k, "R8");
      step(1'b1, 32767, 32767, 32767, 32767, k, "R8");
      step(1'b1, 32767, -32768, -32768, 32767, k, "R8");
      step(1'b1, -32768, 32767, 32767, -32768, k, "R8");
    end
    for (int k = 0; k < NH; k++) step(1'b1, r16(), r16(), 0, 0, k, "R10");
    for (int i = 0; i < 40; i++) begin
      step(1'b1, r16(), r16(), r16(), r16(), i % NH, "R5");
      step(1'b0, r16(), r16(), r16(), r16(), (i + 3) % NH, "R6");
      step(1'b0, r16(), r16(), r16(), r16(), (i + 5) % NH, "R6");
    end
    for (int i = 0; i < 200; i++) step(1'b1, r16(), r16(), r16() | 1, r16(), i % NH, "R9 R2 R3");
    step(1'b0, 0, 0, 0, 0, 0, "R6");
    step(1'b0, 0, 0, 0, 0, 0, "R6");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule